// File: doc/BRIEF.md
# Self-Seeding PRBS-25 Word Checker

This block watches a stream of parallel words that are supposed to carry a 25-stage pseudo-random bit sequence. The sequence obeys the recurrence b[n] = b[n-25] xor b[n-22]. The checker needs no alignment search and no framing. It takes the first received bits as the state of a local generator. It then predicts one word ahead and checks whether the next received word matches that prediction. A match means the checker has locked.

Once locked, the local generator runs on its own predictions and no longer copies the line. Each received word is XORed with the prediction. The number of differing bits adds to a saturating bit-error total, and each compared word adds to a saturating word total. If too many words in a window of recent words disagree, the checker treats the lock as lost and seeds again from the line. A resync request clears the totals and starts seeding over. This lets a bit-error-rate measurement start from zero at any moment.

Top module: `prbs25_lock_checker`

## Requirements
- R1: After reset `locked` is 0 and both `err_bits` and `chk_words` are 0.
- R2: Word bit 0 is the earliest stream bit and bit W-1 is the latest. The expected stream satisfies b[n] = b[n-25] xor b[n-22]. A correct stream produces lock, and a stream that breaks the recurrence (repeated 0x55 words for W=8) never produces lock.
- R3: After reset, after a resync or after loss of lock, the first ceil(25/W) accepted words (4 for W=8) are loaded into the local generator. The next accepted word is compared with the prediction. If it matches, `locked` is 1 from the cycle after that word. If it does not match, seeding restarts.
- R4: In the locked state each accepted word adds 1 to `chk_words` and adds the population count of (predicted xor received) to `err_bits`. The generator advances on its own predicted bits. Words taken while seeding or on the first compare add nothing.
- R5: The mismatching-word count restarts when lock is reached and after every 64 locked words. When it goes above THRESH (8) within a window, `locked` clears in the next cycle and seeding restarts. Exactly 8 mismatching words in a window keep the lock.
- R6: `err_bits` and `chk_words` each stop at their all-ones value and do not wrap.
- R7: A cycle with `resync` high clears `err_bits`, `chk_words` and `locked` in the next cycle and starts seeding again. A word offered in that same cycle is discarded.
- R8: A cycle with `rx_valid` low or `enable` low has no effect. The counts, the lock and the generator state are left as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enable | input | 1 | Accepts words when high |
| rx_word | input | W | Received word, bit 0 first in the stream |
| rx_valid | input | 1 | rx_word carries a new word |
| resync | input | 1 | Clears the totals and forces re-seeding |
| locked | output | 1 | Local generator tracks the stream |
| err_bits | output | CNT_W | Saturating count of mismatched bits |
| chk_words | output | CNT_W | Saturating count of compared words |

## Verification
The hardest case to reach from the ports is the exact edge of the loss-of-lock rule. Eight bad words inside one window must keep the lock, while a ninth bad word in the same window must drop it. The stimulus therefore resyncs first, so the window start is known. It then places eight single-bit errors early in the first window and finishes that window clean. The next window opens with nine consecutive corrupted words. A seed corrupted at a bit that falls into a tap of the first compared word is used to force the check-failure path. Saturation is reached on a narrow-counter copy of the block, which is driven by a long run of fully inverted words spread thinly enough across windows to stay locked.

// File: rtl/prbs_chk_pkg.sv
package prbs_chk_pkg;
    localparam int PRBS_LEN = 25;
    localparam int TAP_FAR  = 25;
    localparam int TAP_NEAR = 22;

    typedef logic [PRBS_LEN-1:0] prbs_state_t;

    typedef enum logic [1:0] {
        ST_SEED  = 2'd0,
        ST_CHECK = 2'd1,
        ST_LOCK  = 2'd2
    } chk_state_t;
endpackage

// File: rtl/prbs_word_predict.sv
module prbs_word_predict
    import prbs_chk_pkg::*;
#(
    parameter int W = 8
) (
    input  prbs_state_t st_i,
    input  logic [W-1:0] rx_i,
    output logic [W-1:0] pred_o,
    output prbs_state_t  gen_o,
    output prbs_state_t  rxs_o
);
    // st[0] holds the newest bit, st[k-1] the bit k places back
    always_comb begin
        prbs_state_t g;
        prbs_state_t r;
        logic [W-1:0] p;
        logic nb;
        g = st_i;
        r = st_i;
        p = '0;
        for (int i = 0; i < W; i++) begin
            nb   = g[TAP_FAR-1] ^ g[TAP_NEAR-1];
            p[i] = nb;
            g    = {g[PRBS_LEN-2:0], nb};
            r    = {r[PRBS_LEN-2:0], rx_i[i]};
        end
        pred_o = p;
        gen_o  = g;
        rxs_o  = r;
    end
endmodule

// File: rtl/prbs_err_window.sv
module prbs_err_window #(
    parameter int WIN    = 64,
    parameter int THRESH = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic step,
    input  logic miss,
    output logic trip
);
    localparam int WIN_W = (WIN > 1) ? $clog2(WIN) : 1;
    localparam int MIS_W = $clog2(THRESH + 2);

    typedef struct packed {
        logic [WIN_W-1:0] win;
        logic [MIS_W-1:0] mis;
    } win_t;

    win_t q, d;
    logic [MIS_W-1:0] mis_n;

    always_comb begin
        mis_n = q.mis + MIS_W'(miss);
        trip  = step && miss && (int'(mis_n) > THRESH);
        d     = q;
        if (clear || trip) begin
            d = '0;
        end else if (step) begin
            if (int'(q.win) == WIN - 1) begin
                d = '0;
            end else begin
                d.win = q.win + 1'b1;
                d.mis = mis_n;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R5
    mis_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        int'(q.mis) <= THRESH);
    // R5
    win_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !clear && int'(q.win) == WIN - 1) |=> (q.win == '0 && q.mis == '0));
endmodule

// File: rtl/prbs_sat_accum.sv
module prbs_sat_accum #(
    parameter int CW = 32,
    parameter int AW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          add_en,
    input  logic [AW-1:0] add_val,
    output logic [CW-1:0] cnt_o
);
    logic [CW-1:0] cnt_q, cnt_d;
    logic [CW:0]   sum;

    always_comb begin
        sum   = {1'b0, cnt_q} + (CW+1)'(add_val);
        cnt_d = cnt_q;
        if (clr)         cnt_d = '0;
        else if (add_en) cnt_d = sum[CW] ? '1 : sum[CW-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

    // R6
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr |=> cnt_q >= $past(cnt_q));
    // R6
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '1 && !clr) |=> cnt_q == '1);
endmodule

// File: rtl/prbs25_lock_checker.sv
module prbs25_lock_checker
    import prbs_chk_pkg::*;
#(
    parameter int W      = 8,
    parameter int CNT_W  = 32,
    parameter int WIN    = 64,
    parameter int THRESH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic [W-1:0]     rx_word,
    input  logic             rx_valid,
    input  logic             resync,
    output logic             locked,
    output logic [CNT_W-1:0] err_bits,
    output logic [CNT_W-1:0] chk_words
);
    localparam int NSEED = (PRBS_LEN + W - 1) / W;
    localparam int SC_W  = $clog2(NSEED + 1);
    localparam int AW    = $clog2(W + 1);

    typedef struct packed {
        chk_state_t       st;
        prbs_state_t      gen;
        logic [SC_W-1:0]  scnt;
    } ctl_t;

    ctl_t q, d;

    logic [W-1:0] pred_w, diff_w;
    prbs_state_t  gen_adv, rx_adv;
    logic         take, lock_step, trip, win_clear;
    logic [AW-1:0] ones;

    prbs_word_predict #(.W(W)) u_pred (
        .st_i  (q.gen),
        .rx_i  (rx_word),
        .pred_o(pred_w),
        .gen_o (gen_adv),
        .rxs_o (rx_adv)
    );

    always_comb begin
        take      = rx_valid && enable && !resync;
        lock_step = take && (q.st == ST_LOCK);
        win_clear = resync || (q.st != ST_LOCK);
        diff_w    = pred_w ^ rx_word;
        ones      = AW'($countones(diff_w));

        d = q;
        if (resync) begin
            d.st   = ST_SEED;
            d.scnt = '0;
        end else if (take) begin
            unique case (q.st)
                ST_SEED: begin
                    d.gen = rx_adv;
                    if (q.scnt == SC_W'(NSEED - 1)) begin
                        d.st   = ST_CHECK;
                        d.scnt = '0;
                    end else begin
                        d.scnt = q.scnt + 1'b1;
                    end
                end
                ST_CHECK: begin
                    d.gen  = rx_adv;
                    d.scnt = '0;
                    d.st   = (diff_w == '0) ? ST_LOCK : ST_SEED;
                end
                ST_LOCK: begin
                    d.gen = gen_adv;
                    if (trip) begin
                        d.st   = ST_SEED;
                        d.scnt = '0;
                    end
                end
                default: d.st = ST_SEED;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q.st   <= ST_SEED;
            q.gen  <= '0;
            q.scnt <= '0;
        end else begin
            q <= d;
        end
    end

    prbs_err_window #(.WIN(WIN), .THRESH(THRESH)) u_win (
        .clk  (clk),
        .rst_n(rst_n),
        .clear(win_clear),
        .step (lock_step),
        .miss (diff_w != '0),
        .trip (trip)
    );

    prbs_sat_accum #(.CW(CNT_W), .AW(AW)) u_bits (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (resync),
        .add_en (lock_step),
        .add_val(ones),
        .cnt_o  (err_bits)
    );

    prbs_sat_accum #(.CW(CNT_W), .AW(1)) u_words (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr    (resync),
        .add_en (lock_step),
        .add_val(1'b1),
        .cnt_o  (chk_words)
    );

    assign locked = (q.st == ST_LOCK);

    // R7
    resync_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resync |=> (!locked && err_bits == '0 && chk_words == '0));
    // R8
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(rx_valid && enable) && !resync) |=>
            ($stable(locked) && $stable(err_bits) && $stable(chk_words) && $stable(q.gen)));
    // R3
    lock_via_check_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(q.st) == ST_CHECK);
    // R4
    word_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !resync |=> (chk_words - $past(chk_words)) <= CNT_W'(1));
    // R4
    unlocked_no_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!locked && !resync) |=> $stable(chk_words));
endmodule

// File: tb/tb_prbs25_lock_checker.sv
`timescale 1ns/1ps
module tb_prbs25_lock_checker;
    localparam int W      = 8;
    localparam int WIN    = 64;
    localparam int THR    = 8;
    localparam int NSEED  = (25 + W - 1) / W;
    localparam int SAT_W  = 8;
    localparam longint SAT_MAX = (64'd1 << SAT_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0;
    logic rx_valid = 1'b0;
    logic resync = 1'b0;
    logic [W-1:0] rx_word = '0;

    logic locked, locked_s;
    logic [31:0] err_bits, chk_words;
    logic [SAT_W-1:0] err_s, words_s;

    always #2.5 clk = ~clk;

    prbs25_lock_checker #(.W(W), .CNT_W(32), .WIN(WIN), .THRESH(THR)) dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .rx_word(rx_word),
        .rx_valid(rx_valid), .resync(resync), .locked(locked),
        .err_bits(err_bits), .chk_words(chk_words));

    prbs25_lock_checker #(.W(W), .CNT_W(SAT_W), .WIN(WIN), .THRESH(THR)) dut_sat (
        .clk(clk), .rst_n(rst_n), .enable(enable), .rx_word(rx_word),
        .rx_valid(rx_valid), .resync(resync), .locked(locked_s),
        .err_bits(err_s), .chk_words(words_s));

    int total = 0;
    int bad = 0;
    string cur_req = "R1";

    // reference model
    bit     mh[$];
    int     m_state;   // 0 seeding, 1 first compare, 2 locked
    int     m_scnt, m_win, m_mis;
    longint m_bits, m_words;

    // transmitter
    bit tq[$];

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [W-1:0] tx_word();
        logic [W-1:0] w;
        for (int i = 0; i < W; i++) begin
            bit nb;
            nb = tq[0] ^ tq[3];
            tq.push_back(nb);
            void'(tq.pop_front());
            w[i] = nb;
        end
        return w;
    endfunction

    function automatic logic [W-1:0] model_pred();
        bit t[$];
        logic [W-1:0] p;
        t = mh;
        for (int i = 0; i < W; i++) begin
            bit nb;
            nb = t[t.size()-25] ^ t[t.size()-22];
            t.push_back(nb);
            p[i] = nb;
        end
        return p;
    endfunction

    task automatic push_bits(input logic [W-1:0] w);
        for (int i = 0; i < W; i++) begin
            mh.push_back(w[i]);
            void'(mh.pop_front());
        end
    endtask

    task automatic model_reset();
        mh.delete();
        for (int i = 0; i < 25; i++) mh.push_back(1'b0);
        m_state = 0; m_scnt = 0; m_win = 0; m_mis = 0;
        m_bits = 0; m_words = 0;
    endtask

    task automatic model_update(input logic v, input logic [W-1:0] w,
                                input logic rs, input logic en);
        logic [W-1:0] p;
        if (rs) begin
            m_bits = 0; m_words = 0; m_state = 0; m_scnt = 0;
        end else if (v && en) begin
            p = model_pred();
            case (m_state)
                0: begin
                    push_bits(w);
                    m_scnt++;
                    if (m_scnt == NSEED) begin m_state = 1; m_scnt = 0; end
                end
                1: begin
                    push_bits(w);
                    if (p == w) begin m_state = 2; m_win = 0; m_mis = 0; end
                    else m_state = 0;
                end
                default: begin
                    push_bits(p);
                    m_words++;
                    m_bits += $countones(p ^ w);
                    if (p != w) m_mis++;
                    if (m_mis > THR) begin
                        m_state = 0; m_scnt = 0;
                    end else begin
                        m_win++;
                        if (m_win == WIN) begin m_win = 0; m_mis = 0; end
                    end
                end
            endcase
        end
    endtask

    task automatic compare_all();
        longint es, ws;
        es = (m_bits > SAT_MAX) ? SAT_MAX : m_bits;
        ws = (m_words > SAT_MAX) ? SAT_MAX : m_words;
        check(locked == (m_state == 2), cur_req, "locked", locked, m_state == 2);
        check(err_bits == m_bits, cur_req, "err_bits", err_bits, m_bits);
        check(chk_words == m_words, cur_req, "chk_words", chk_words, m_words);
        check(locked_s == (m_state == 2), cur_req, "narrow locked", locked_s, m_state == 2);
        check(err_s == es, cur_req, "narrow err_bits", err_s, es);
        check(words_s == ws, cur_req, "narrow chk_words", words_s, ws);
    endtask

    task automatic step(input logic v, input logic [W-1:0] w,
                        input logic rs, input logic en);
        @(negedge clk);
        rx_valid = v; rx_word = w; resync = rs; enable = en;
        @(posedge clk);
        model_update(v, w, rs, en);
        #1;
        compare_all();
    endtask

    task automatic send_clean(input int n);
        for (int i = 0; i < n; i++) step(1'b1, tx_word(), 1'b0, 1'b1);
    endtask

    task automatic send_err(input logic [W-1:0] flip);
        step(1'b1, tx_word() ^ flip, 1'b0, 1'b1);
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(5 * 150000);
        bad++;
        $display("FAIL watchdog expired actual=1 expected=0");
        finish_run();
    end

    initial begin
        longint e0;
        tq.delete();
        for (int i = 0; i < 25; i++) tq.push_back(((25'h1A2B3C5 >> i) & 1) != 0);
        model_reset();
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #0.5;

        // R1 reset state
        cur_req = "R1";
        check(locked == 1'b0, "R1", "locked after reset", locked, 0);
        check(err_bits == 0, "R1", "err_bits after reset", err_bits, 0);
        check(chk_words == 0, "R1", "chk_words after reset", chk_words, 0);

        // R3 seeding takes exactly NSEED words, then one compare
        cur_req = "R3";
        send_clean(NSEED);
        check(locked == 1'b0, "R3", "not locked after seed words", locked, 0);
        send_clean(1);
        check(locked == 1'b1, "R3", "locked after compare word", locked, 1);

        // R2 correct recurrence and bit order keep a clean run error free
        cur_req = "R2";
        for (int i = 0; i < 20; i++) begin
            if (i % 3 == 2) step(1'b0, 8'hA5, 1'b0, 1'b1);
            else send_clean(1);
        end
        check(err_bits == 0, "R2", "clean stream error free", err_bits, 0);

        // R4 popcount accumulation
        cur_req = "R4";
        e0 = err_bits;
        send_err(8'h10);
        send_err(8'h07);
        check(err_bits == e0 + 4, "R4", "err_bits popcount", err_bits, e0 + 4);

        // R8 ignored words
        cur_req = "R8";
        e0 = err_bits;
        step(1'b1, 8'hFF, 1'b0, 1'b0);
        step(1'b0, 8'h3C, 1'b0, 1'b1);
        send_clean(3);
        check(err_bits == e0, "R8", "gated words left no trace", err_bits, e0);
        check(locked == 1'b1, "R8", "lock kept", locked, 1);

        // R5 boundary: 8 bad words in a fresh window keep lock
        cur_req = "R5";
        step(1'b0, '0, 1'b1, 1'b1);
        send_clean(NSEED + 1);
        for (int i = 0; i < WIN; i++) begin
            if (i >= 2 && i < 18 && (i % 2 == 0)) send_err(8'h01);
            else send_clean(1);
        end
        check(locked == 1'b1, "R5", "8 bad words keep lock", locked, 1);
        for (int i = 0; i < 8; i++) send_err(8'h80);
        check(locked == 1'b1, "R5", "lock held at 8 in window", locked, 1);
        send_err(8'h80);
        check(locked == 1'b0, "R5", "ninth bad word drops lock", locked, 0);
        send_clean(NSEED + 1);
        check(locked == 1'b1, "R5", "relocked after loss", locked, 1);

        // R3 corrupted seed forces reseed
        cur_req = "R3";
        step(1'b0, '0, 1'b1, 1'b1);
        send_clean(2);
        send_err(8'h01);
        send_clean(NSEED - 2);
        check(locked == 1'b0, "R3", "bad seed fails compare", locked, 0);
        send_clean(NSEED + 1);
        check(locked == 1'b1, "R3", "lock after reseed", locked, 1);

        // R7 resync with a word in the same cycle
        cur_req = "R7";
        send_err(8'h03);
        step(1'b1, tx_word(), 1'b1, 1'b1);
        check(err_bits == 0 && chk_words == 0, "R7", "counts cleared",
              err_bits + chk_words, 0);
        check(locked == 1'b0, "R7", "lock cleared", locked, 0);
        send_clean(NSEED);
        check(locked == 1'b0, "R7", "same-cycle word discarded", locked, 0);
        send_clean(1);
        check(locked == 1'b1, "R7", "relock after resync", locked, 1);

        // R6 saturation on the narrow copy
        cur_req = "R6";
        for (int b = 0; b < 9; b++) begin
            for (int i = 0; i < WIN; i++) begin
                if (i < 4) send_err(8'hFF);
                else send_clean(1);
            end
        end
        check(err_s == SAT_MAX[SAT_W-1:0], "R6", "narrow err_bits saturates", err_s, SAT_MAX);
        check(words_s == SAT_MAX[SAT_W-1:0], "R6", "narrow chk_words saturates", words_s, SAT_MAX);
        check(err_bits == 32'd288, "R6", "wide err_bits keeps counting", err_bits, 288);

        // R2 stream breaking the recurrence never locks
        cur_req = "R2";
        step(1'b0, '0, 1'b1, 1'b1);
        for (int i = 0; i < 60; i++) step(1'b1, 8'h55, 1'b0, 1'b1);
        check(locked == 1'b0, "R2", "0x55 stream never locks", locked, 0);

        finish_run();
    end
endmodule